// File: doc/BRIEF.md
# Stuck-At Signal Watchdog Monitor

The monitor samples one single-bit signal on every rising clock edge and counts how many consecutive edges it has seen the signal keep the level it had at the previous edge. When that quiet time reaches a limit, it raises a warning flag for the level the signal is held at. Stuck-high and stuck-low conditions have separate limits, set as parameters in clock cycles. By default the stuck-high limit is the shorter of the two, in a 3:4 ratio (300 and 400 cycles). Each limit must be at least 1.

The flags are indications only; the monitored signal and the logic around it are left untouched. On the first edge after reset the monitor only captures the signal's level, so the level present at power-up is never compared against a stale value. An enable input switches the detector off. While it is off, the quiet-time count is held at zero.

A pair of sticky flags keeps a record of any live flag that has been raised, even after the signal starts toggling again. The record is cleared by reset or by a clear input. A parameter can build the monitor without the sticky record, in which case both sticky outputs are tied low.

Top module: `stuck_watch`

## Requirements
- R1: While rst_n is low, and on the first cycle after a reset edge, all four outputs are low.
- R2: stuck_hi is high exactly when en is high, the level captured at the last edge is 1, and the signal has matched its previous-edge value on at least TH_HI consecutive edges. The flag is first high in the cycle after the TH_HI-th such edge.
- R3: stuck_lo is high exactly when en is high, the captured level is 0, and the signal has matched its previous-edge value on at least TH_LO consecutive edges.
- R4: The two limits act independently. With TH_HI=3 and TH_LO=4, a run that is long enough for high is too short for low.
- R5: The first edge after reset release only captures the level and counts nothing. A level held from before reset therefore needs TH+1 edges to be flagged.
- R6: Any change of the signal restarts the quiet count. The live flag drops in the cycle after the edge that samples the change.
- R7: The count saturates rather than wrapping, so a live flag stays high for as long as the level is held.
- R8: While en is low, both live flags are low and the count is held at zero. After en returns high, the count starts again from zero.
- R9: Each sticky flag is set one cycle after its live flag is high at an edge. It stays set after the signal toggles, until sticky_clr or reset.
- R10: sticky_clr high at an edge clears both sticky flags, even when a live flag is high at that same edge.
- R11: With STICKY_EN=0, sticky_hi and sticky_lo stay low, and the live flags behave as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Detector enable |
| sig_in | input | 1 | Monitored bit |
| sticky_clr | input | 1 | Clears both sticky flags |
| stuck_hi | output | 1 | Live stuck-at-1 warning |
| stuck_lo | output | 1 | Live stuck-at-0 warning |
| sticky_hi | output | 1 | Recorded stuck-at-1 warning |
| sticky_lo | output | 1 | Recorded stuck-at-0 warning |

## Verification
The embedded assertions check four properties on every cycle:
- a change on the signal zeroes the count;
- a saturated count holds;
- the two live flags are never high together, and both are low when disabled;
- a clear empties the sticky record, and a live flag sets it unless a clear is present.

Only the bench scenarios can show that the flags appear on exactly the right cycle for each run length. The same holds for the startup guard, for the independence of the two limits, and for the variant built without the sticky record. To cover these, the bench sweeps runs of every length from 1 to 7 at both levels, and uses long holds, enable gaps and clears placed against live flags.

// File: rtl/stuck_watch_pkg.sv
// Package: shared types and helpers for the stuck-at watchdog.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package stuck_watch_pkg;

    // Pair of polarity flags carried between submodules.
    typedef struct packed {
        logic hi;
        logic lo;
    } pol_flags_t;

    // Larger of two limits, used to size the counter.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/stuck_quiet_ctr.sv
// Module: quiet-time counter.
// Captures the monitored bit every edge and counts consecutive edges on
// which it equals the captured value. The first edge after reset only
// primes the capture (startup guard). Disable holds the count at zero.
// Assumes CW is wide enough to hold the largest limit.
module stuck_quiet_ctr #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sig_in,
    output logic          level,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic primed;

    // Capture level, arm the startup guard, advance or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed <= 1'b0;
            level  <= 1'b0;
            cnt    <= '0;
        end else begin
            primed <= 1'b1;
            level  <= sig_in;
            if (!primed || !en || (sig_in != level)) begin
                cnt <= '0;
            end else if (cnt != CMAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: a sampled change restarts the count
    a_r6_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && (sig_in != level)) |=> (cnt == '0));

    // R7: a full count does not wrap
    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && en && (sig_in == level) && (cnt == CMAX)) |=> (cnt == CMAX));

    // R8: disabled means the count is held at zero
    a_r8_disable_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (cnt == '0));

endmodule

// File: rtl/stuck_live_det.sv
// Module: live flag decoder.
// Compares the quiet count with the limit of the captured level and
// gates the result with enable. Purely combinational.
// Assumes TH_HI and TH_LO are at least 1 and fit in CW bits.
module stuck_live_det
    import stuck_watch_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned TH_HI = 3,
    parameter int unsigned TH_LO = 4
) (
    input  logic          en,
    input  logic          level,
    input  logic [CW-1:0] cnt,
    output pol_flags_t    live
);
    localparam logic [CW-1:0] LIM_HI = CW'(TH_HI);
    localparam logic [CW-1:0] LIM_LO = CW'(TH_LO);

    // Raise the flag of the held level once its limit is reached.
    always_comb begin
        live.hi = en &&  level && (cnt >= LIM_HI);
        live.lo = en && !level && (cnt >= LIM_LO);
    end

endmodule

// File: rtl/stuck_sticky.sv
// Module: sticky fault record.
// Latches each live flag until clear or reset; clear wins over set.
// With STICKY_EN=0 the record is not built and the outputs are zero.
module stuck_sticky
    import stuck_watch_pkg::*;
#(
    parameter bit STICKY_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  pol_flags_t live,
    output pol_flags_t rec
);
    if (STICKY_EN) begin : g_rec
        pol_flags_t rec_q;

        // Accumulate live flags; clear takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                rec_q <= '0;
            end else begin
                rec_q <= rec_q | live;
            end
        end

        assign rec = rec_q;

        // R10: clear leaves the record empty
        a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (rec == '0));

        // R9: a live high flag is recorded unless cleared
        a_r9_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (live.hi && !clr) |=> rec.hi);

        a_r9_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (live.lo && !clr) |=> rec.lo);
    end else begin : g_none
        assign rec = '0;
    end

endmodule

// File: rtl/stuck_watch.sv
// Module: stuck-at watchdog top.
// Watches one bit and warns when it holds 1 for TH_HI edges or 0 for
// TH_LO edges. The warnings never feed back into the watched logic.
// Assumes sig_in is already synchronous to clk; TH_HI, TH_LO >= 1.
module stuck_watch
    import stuck_watch_pkg::*;
#(
    parameter int unsigned TH_HI     = 300,
    parameter int unsigned TH_LO     = 400,
    parameter bit          STICKY_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sig_in,
    input  logic sticky_clr,
    output logic stuck_hi,
    output logic stuck_lo,
    output logic sticky_hi,
    output logic sticky_lo
);
    localparam int unsigned TH_MAX = umax(TH_HI, TH_LO);
    localparam int unsigned CW     = $clog2(TH_MAX + 1);

    logic          level;
    logic [CW-1:0] cnt;
    pol_flags_t    live;
    pol_flags_t    rec;

    stuck_quiet_ctr #(.CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .sig_in (sig_in),
        .level  (level),
        .cnt    (cnt)
    );

    stuck_live_det #(.CW(CW), .TH_HI(TH_HI), .TH_LO(TH_LO)) u_det (
        .en    (en),
        .level (level),
        .cnt   (cnt),
        .live  (live)
    );

    stuck_sticky #(.STICKY_EN(STICKY_EN)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sticky_clr),
        .live  (live),
        .rec   (rec)
    );

    // Drive the output pins from the internal flag pairs.
    always_comb begin
        stuck_hi  = live.hi;
        stuck_lo  = live.lo;
        sticky_hi = rec.hi;
        sticky_lo = rec.lo;
    end

    // R2 R3: a single level cannot be stuck both ways
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stuck_hi && stuck_lo));

    // R8: no live warning while disabled
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (!stuck_hi && !stuck_lo));

endmodule

// File: tb/stuck_watch_bench.sv
// Bench: cycle-stepped sweep with a model written from the requirements.
module stuck_watch_bench;
    localparam int unsigned TH_HI = 3;
    localparam int unsigned TH_LO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sig_in = 1'b0;
    logic sticky_clr = 1'b0;
    logic stuck_hi, stuck_lo, sticky_hi, sticky_lo;
    logic n_hi, n_lo, n_shi, n_slo;

    int total = 0;
    int bad = 0;

    // Bench model state
    logic m_primed = 1'b0;
    logic m_prev = 1'b0;
    int   m_run = 0;
    logic m_shi = 1'b0;
    logic m_slo = 1'b0;

    always #10 clk = ~clk;

    stuck_watch #(.TH_HI(TH_HI), .TH_LO(TH_LO), .STICKY_EN(1'b1)) u_stuck_watch (
        .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .sticky_clr(sticky_clr),
        .stuck_hi(stuck_hi), .stuck_lo(stuck_lo), .sticky_hi(sticky_hi), .sticky_lo(sticky_lo)
    );

    stuck_watch #(.TH_HI(TH_HI), .TH_LO(TH_LO), .STICKY_EN(1'b0)) u_stuck_watch_nosticky (
        .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .sticky_clr(sticky_clr),
        .stuck_hi(n_hi), .stuck_lo(n_lo), .sticky_hi(n_shi), .sticky_lo(n_slo)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, model the edge, check at the next negedge.
    task automatic step(input logic s, input logic e, input logic c, input string tag);
        logic live_hi, live_lo;
        sig_in = s; en = e; sticky_clr = c;
        live_hi = e &&  m_prev && m_primed && (m_run >= TH_HI);
        live_lo = e && !m_prev && m_primed && (m_run >= TH_LO);
        @(posedge clk);
        m_shi = c ? 1'b0 : (m_shi | live_hi);
        m_slo = c ? 1'b0 : (m_slo | live_lo);
        if (!m_primed || !e || (s != m_prev)) m_run = 0;
        else m_run = m_run + 1;
        m_prev = s;
        m_primed = 1'b1;
        @(negedge clk);
        live_hi = e &&  m_prev && (m_run >= TH_HI);
        live_lo = e && !m_prev && (m_run >= TH_LO);
        check({stuck_hi, stuck_lo, sticky_hi, sticky_lo},
              {live_hi, live_lo, m_shi, m_slo}, tag);
        check({n_hi, n_lo, n_shi, n_slo}, {live_hi, live_lo, 2'b00}, {tag, " R11"});
    endtask

    // Apply reset for a few cycles with the input held, then release.
    task automatic do_reset(input logic s);
        sig_in = s; rst_n = 1'b0; en = 1'b1; sticky_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({stuck_hi, stuck_lo, sticky_hi, sticky_lo}, 4'b0000, "R1 in reset");
        check({n_hi, n_lo, n_shi, n_slo}, 4'b0000, "R1 in reset R11");
        m_primed = 1'b0; m_prev = 1'b0; m_run = 0; m_shi = 1'b0; m_slo = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic lvl;
        @(negedge clk);
        // R1 R5: level 1 held through reset, guard delays the flag one edge
        do_reset(1'b1);
        step(1'b1, 1'b1, 1'b0, "R1 first cycle");
        repeat (7) step(1'b1, 1'b1, 1'b0, "R5 startup guard");
        // R9: sticky survives toggling
        repeat (3) step(1'b0, 1'b1, 1'b0, "R9 sticky holds");
        step(1'b1, 1'b1, 1'b1, "R10 clear");
        // R2 R3 R4 R6: runs of every length at alternating levels
        lvl = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int n = 1; n <= 7; n++) begin
                repeat (n) step(lvl, 1'b1, 1'b0, "R2 R3 R4 R6 sweep");
                lvl = ~lvl;
            end
            step(lvl, 1'b1, 1'b1, "R10 clear between passes");
        end
        // R7: long holds past counter saturation
        repeat (20) step(1'b1, 1'b1, 1'b0, "R7 long high");
        repeat (25) step(1'b0, 1'b1, 1'b0, "R7 long low");
        // R10: clear at an edge where the live flag is high
        step(1'b0, 1'b1, 1'b1, "R10 clear beats set");
        step(1'b0, 1'b1, 1'b0, "R10 set after clear");
        // R8: disable mid-run, then re-enable
        repeat (3) step(1'b0, 1'b0, 1'b0, "R8 disabled");
        repeat (6) step(1'b0, 1'b1, 1'b0, "R8 restart");
        repeat (5) step(1'b1, 1'b1, 1'b0, "R8 high run");
        step(1'b1, 1'b0, 1'b0, "R8 disable drops flag");
        repeat (4) step(1'b1, 1'b1, 1'b0, "R8 recount");
        // R1: reset clears a live and sticky fault, level 0 held across
        repeat (6) step(1'b0, 1'b1, 1'b0, "R3 before reset");
        do_reset(1'b0);
        step(1'b0, 1'b1, 1'b0, "R1 first cycle after reset");
        repeat (6) step(1'b0, 1'b1, 1'b0, "R5 guard low");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule